// File: doc/BRIEF.md
# Register-mapped SPI master

This block is a serial peripheral interface master that a processor drives through a small 32-bit register bus made of a byte address, a write strobe, a read strobe, write data and read data. Software picks the serial clock rate with a 12-bit divider and picks one of the four clock polarity and phase modes. It sets the frame length from 1 to 8 bits and the bit order, then pushes bytes into an 8-entry transmit queue. The controller sends queued bytes one frame at a time on a single data-out and data-in lane. Each frame returns one received byte into an 8-entry receive queue.

Several select lines are driven from a default-level register, so each line can be active low or active high. The line addressed by the select index is asserted in one of three ways. In automatic mode it is asserted only while a frame runs. In held mode it stays asserted between frames until the select settings are rewritten with a different value. In off mode it is never asserted. Queue status needs no separate register: the top bit of the transmit data word shows that the queue is full, and the top bit of the receive data word shows that it is empty. A read of the receive word removes one entry.

Top module: `spi_master_regs`

## Requirements
- R1: After reset the divider reads 3, the clock mode reads 0, the select index reads 0, the select mode reads 0 (automatic), the frame format reads 0x0008_0000 (8-bit, MSB first), the serial clock is low and every select line is at its default level.
- R2: Each half period of the serial clock lasts (div+1) input clock cycles, where div is bits [11:0] of the register at offset 0x00. The serial clock rate is therefore the input rate divided by 2*(div+1).
- R3: In the register at 0x04, bit 1 sets the idle level of the serial clock and bit 0 sets the phase. With phase 0 the input is sampled on the first edge of each bit, and with phase 1 on the second edge. Looped-back data returns intact in all four modes.
- R4: The register at 0x40 holds the frame length in bits [19:16] (1 to 8; 0 or above 8 acts as 8) and the bit order in bit 2 (0 = MSB first, 1 = LSB first). Exactly that many bits are shifted in that order.
- R5: A write to 0x48 pushes bits [7:0] into the 8-entry transmit queue, and the write is dropped when the queue is full. A read of 0x48 returns bit 31 set exactly when the queue is full.
- R6: A read of 0x4C returns the oldest received byte in bits [7:0] with bit 31 clear, and removes it. When the queue is empty the read returns 0x8000_0000 and removes nothing.
- R7: Every transmitted frame puts exactly one byte, right-aligned, into the receive queue. A new frame does not start while that queue is full, so no received byte is lost.
- R8: With select mode 0 at offset 0x18, the line chosen by the index at 0x10 is driven to the inverse of its default level during a frame only. All other lines stay at their default levels.
- R9: With select mode 2, the chosen line becomes active with the first frame and stays active after it. It is released only by a write to 0x10, 0x14 or 0x18 that changes the stored value.
- R10: With select mode 3, frames still run, but every select line stays at its default level.
- R11: The register at 0x14 holds one default-level bit per select line and resets to all ones, so its reset value reveals how many lines exist. Clearing a bit makes that line idle low and active high.
- R12: Writes to 0x28, 0x50, 0x70 and 0x74 change nothing, and those offsets read 0. The register at 0x60 stores bit 0, resets to 1 and reads back. The lane field in bits [1:0] of 0x40 is stored but frames always use the single lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 7 | Byte address of the register |
| busWe | input | 1 | Write strobe, one cycle per write |
| busRe | input | 1 | Read strobe; a receive-word read removes one entry at the clock edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, valid in the same cycle |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | CS_NUM | Select lines, at their default level when inactive |

## Verification
The bench loops the data-out line back to the data-in line and watches the serial clock. It records the data and select levels on every sampling edge, so it can catch a design that samples on the wrong edge, reverses the bit order, or shifts one bit too many or too few. A design that counts the divider off by one shows up as a half period of the wrong length. The bench fills the transmit queue while the receive queue is full. A design that overruns would lose a byte, and one that lets the queue overflow would send a ninth queued byte that should have been dropped. The held-select test rewrites the index with its current value and then with a new one. A design that releases on any write, or never releases, gives the wrong line level. Inverted default levels and off mode show whether the active level comes from the default register and whether off mode really leaves the lines alone.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int ADDR_W = 7;
  localparam int DIV_W  = 12;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 4;

  localparam logic [ADDR_W-1:0] ADR_SCKDIV  = 7'h00;
  localparam logic [ADDR_W-1:0] ADR_SCKMODE = 7'h04;
  localparam logic [ADDR_W-1:0] ADR_CSIDX   = 7'h10;
  localparam logic [ADDR_W-1:0] ADR_CSDEF   = 7'h14;
  localparam logic [ADDR_W-1:0] ADR_CSMODE  = 7'h18;
  localparam logic [ADDR_W-1:0] ADR_FMT     = 7'h40;
  localparam logic [ADDR_W-1:0] ADR_TXWORD  = 7'h48;
  localparam logic [ADDR_W-1:0] ADR_RXWORD  = 7'h4C;
  localparam logic [ADDR_W-1:0] ADR_FLASH   = 7'h60;

  typedef enum logic [1:0] {
    CSM_AUTO = 2'd0,
    CSM_ALT  = 2'd1,
    CSM_HOLD = 2'd2,
    CSM_OFF  = 2'd3
  } csMode_e;

  // strobes and frame settings handed from control to the shift engine
  typedef struct packed {
    logic              start;
    logic [BYTE_W-1:0] txByte;
    logic [LEN_W-1:0]  frameLen;
    logic              lsbFirst;
    logic              cpol;
    logic              cpha;
    logic [DIV_W-1:0]  divVal;
  } engCmd_t;

  function automatic logic [LEN_W-1:0] effLen(input logic [LEN_W-1:0] raw);
    return (raw == '0 || raw > 4'd8) ? 4'd8 : raw;
  endfunction
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout  = mem[rdPtr];
  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rstN) push |-> !full);
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rstN) pop |-> !empty);
endmodule

// File: rtl/spim_datapath.sv
module spim_datapath
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  engCmd_t           cmd,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              idle,
  output logic              frameDone,
  output logic [BYTE_W-1:0] rxByte
);
  logic              running;
  logic [DIV_W-1:0]  halfCnt, divQ;
  logic [4:0]        edgeCnt;
  logic [LEN_W-1:0]  lenQ;
  logic              lsbQ, cphaQ, cpolQ, sckQ;
  logic [BYTE_W-1:0] txSh, rxSh, rxNext;
  logic              tick, sampleEdge, shiftEdge, lastEdge;

  assign tick       = running && (halfCnt == divQ);
  // even edge index = leading edge of a bit, odd = trailing edge
  assign sampleEdge = cphaQ ? edgeCnt[0] : ~edgeCnt[0];
  assign shiftEdge  = cphaQ ? (~edgeCnt[0] && (edgeCnt != 5'd0)) : edgeCnt[0];
  assign lastEdge   = (edgeCnt == (({1'b0, lenQ} << 1) - 5'd1));

  always_comb begin
    if (!sampleEdge)  rxNext = rxSh;
    else if (lsbQ)    rxNext = {miso, rxSh[BYTE_W-1:1]};
    else              rxNext = {rxSh[BYTE_W-2:0], miso};
  end

  assign rxByte    = lsbQ ? (rxNext >> (4'd8 - lenQ)) : rxNext;
  assign frameDone = tick && lastEdge;
  assign idle      = !running;
  assign sck       = sckQ;
  assign mosi      = lsbQ ? txSh[0] : txSh[BYTE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      halfCnt <= '0;
      divQ    <= '0;
      edgeCnt <= '0;
      lenQ    <= 4'd8;
      lsbQ    <= 1'b0;
      cphaQ   <= 1'b0;
      cpolQ   <= 1'b0;
      sckQ    <= 1'b0;
      txSh    <= '0;
      rxSh    <= '0;
    end else if (!running) begin
      sckQ <= cmd.cpol;
      if (cmd.start) begin
        running <= 1'b1;
        halfCnt <= '0;
        edgeCnt <= '0;
        divQ    <= cmd.divVal;
        lenQ    <= cmd.frameLen;
        lsbQ    <= cmd.lsbFirst;
        cphaQ   <= cmd.cpha;
        cpolQ   <= cmd.cpol;
        rxSh    <= '0;
        txSh    <= cmd.lsbFirst ? cmd.txByte : (cmd.txByte << (4'd8 - cmd.frameLen));
      end
    end else if (tick) begin
      halfCnt <= '0;
      edgeCnt <= edgeCnt + 5'd1;
      sckQ    <= lastEdge ? cpolQ : ~sckQ;
      rxSh    <= rxNext;
      if (shiftEdge) txSh <= lsbQ ? (txSh >> 1) : (txSh << 1);
      if (lastEdge)  running <= 1'b0;
    end else begin
      halfCnt <= halfCnt + 1'b1;
    end
  end

  a_r2_sck_steady: assert property (@(posedge clk) disable iff (!rstN)
    (running && !tick) |=> $stable(sck));
  a_r4_start_runs: assert property (@(posedge clk) disable iff (!rstN)
    (idle && cmd.start) |=> !idle);
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int CS_NUM     = 4,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic [CS_NUM-1:0] csN,
  output engCmd_t           cmd,
  input  logic              dpIdle,
  input  logic              frameDone,
  input  logic [BYTE_W-1:0] rxByte
);
  localparam int CS_ID_W = (CS_NUM > 1) ? $clog2(CS_NUM) : 1;

  logic [DIV_W-1:0]   divQ;
  logic               cpolQ, cphaQ;
  logic [CS_ID_W-1:0] csIdQ;
  logic [CS_NUM-1:0]  csDefQ;
  csMode_e            csModeQ;
  logic [1:0]         fmtProto;
  logic               fmtLsb, fmtDir, flashQ, holdQ;
  logic [LEN_W-1:0]   fmtLen;

  logic wrDiv, wrMode, wrCsId, wrCsDef, wrCsMode, wrFmt, wrTx, wrFlash;
  logic txFull, txEmpty, rxFull, rxEmpty, txPush, rxPop, startNow;
  logic csRelease, csAssert, engBusy;
  logic [BYTE_W-1:0] txDout, rxDout;

  assign wrDiv    = busWe && (busAddr == ADR_SCKDIV);
  assign wrMode   = busWe && (busAddr == ADR_SCKMODE);
  assign wrCsId   = busWe && (busAddr == ADR_CSIDX);
  assign wrCsDef  = busWe && (busAddr == ADR_CSDEF);
  assign wrCsMode = busWe && (busAddr == ADR_CSMODE);
  assign wrFmt    = busWe && (busAddr == ADR_FMT);
  assign wrTx     = busWe && (busAddr == ADR_TXWORD);
  assign wrFlash  = busWe && (busAddr == ADR_FLASH);

  assign txPush   = wrTx && !txFull;
  assign rxPop    = busRe && (busAddr == ADR_RXWORD) && !rxEmpty;
  assign startNow = dpIdle && !txEmpty && !rxFull;

  spim_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txFifo (
    .clk, .rstN, .push(txPush), .din(busWdata[BYTE_W-1:0]), .pop(startNow),
    .dout(txDout), .full(txFull), .empty(txEmpty));

  spim_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxFifo (
    .clk, .rstN, .push(frameDone), .din(rxByte), .pop(rxPop),
    .dout(rxDout), .full(rxFull), .empty(rxEmpty));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ     <= DIV_W'(3);
      cpolQ    <= 1'b0;
      cphaQ    <= 1'b0;
      csIdQ    <= '0;
      csDefQ   <= '1;
      csModeQ  <= CSM_AUTO;
      fmtProto <= 2'd0;
      fmtLsb   <= 1'b0;
      fmtDir   <= 1'b0;
      fmtLen   <= 4'd8;
      flashQ   <= 1'b1;
    end else begin
      if (wrDiv)    divQ <= busWdata[DIV_W-1:0];
      if (wrMode)   {cpolQ, cphaQ} <= busWdata[1:0];
      if (wrCsId)   csIdQ <= busWdata[CS_ID_W-1:0];
      if (wrCsDef)  csDefQ <= busWdata[CS_NUM-1:0];
      if (wrCsMode) csModeQ <= csMode_e'(busWdata[1:0]);
      if (wrFmt) begin
        fmtProto <= busWdata[1:0];
        fmtLsb   <= busWdata[2];
        fmtDir   <= busWdata[3];
        fmtLen   <= busWdata[19:16];
      end
      if (wrFlash)  flashQ <= busWdata[0];
    end
  end

  // held select: released only by a select-setting write that changes a value
  assign csRelease = (wrCsId   && (busWdata[CS_ID_W-1:0] != csIdQ))  ||
                     (wrCsDef  && (busWdata[CS_NUM-1:0]  != csDefQ)) ||
                     (wrCsMode && (busWdata[1:0] != 2'(csModeQ)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              holdQ <= 1'b0;
    else if (csRelease)                     holdQ <= 1'b0;
    else if (startNow && csModeQ == CSM_HOLD) holdQ <= 1'b1;
  end

  assign engBusy = !dpIdle || startNow;

  always_comb begin
    case (csModeQ)
      CSM_OFF:  csAssert = 1'b0;
      CSM_HOLD: csAssert = holdQ || engBusy;
      default:  csAssert = engBusy;
    endcase
  end

  for (genvar i = 0; i < CS_NUM; i++) begin : g_cs
    assign csN[i] = csDefQ[i] ^ (csAssert && (csIdQ == CS_ID_W'(i)));
  end

  always_comb begin
    cmd.start    = startNow;
    cmd.txByte   = txDout;
    cmd.frameLen = effLen(fmtLen);
    cmd.lsbFirst = fmtLsb;
    cmd.cpol     = cpolQ;
    cmd.cpha     = cphaQ;
    cmd.divVal   = divQ;
  end

  always_comb begin
    case (busAddr)
      ADR_SCKDIV:  busRdata = 32'(divQ);
      ADR_SCKMODE: busRdata = {30'b0, cpolQ, cphaQ};
      ADR_CSIDX:   busRdata = 32'(csIdQ);
      ADR_CSDEF:   busRdata = 32'(csDefQ);
      ADR_CSMODE:  busRdata = {30'b0, csModeQ};
      ADR_FMT:     busRdata = {12'b0, fmtLen, 12'b0, fmtDir, fmtLsb, fmtProto};
      ADR_TXWORD:  busRdata = {txFull, 31'b0};
      ADR_RXWORD:  busRdata = {rxEmpty, 23'b0, rxEmpty ? 8'h00 : rxDout};
      ADR_FLASH:   busRdata = {31'b0, flashQ};
      default:     busRdata = 32'b0;
    endcase
  end

  a_r7_rx_room: assert property (@(posedge clk) disable iff (!rstN) frameDone |-> !rxFull);
  a_r8_auto_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (csModeQ == CSM_AUTO && dpIdle && txEmpty) |-> (csN == csDefQ));
endmodule

// File: rtl/spi_master_regs.sv
module spi_master_regs
  import spim_pkg::*;
#(
  parameter int CS_NUM     = 4,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [CS_NUM-1:0] csN
);
  engCmd_t           cmd;
  logic              dpIdle, frameDone;
  logic [BYTE_W-1:0] rxByte;

  spim_ctrl #(.CS_NUM(CS_NUM), .FIFO_DEPTH(FIFO_DEPTH)) u_ctrl (
    .clk, .rstN, .busAddr, .busWe, .busRe, .busWdata, .busRdata, .csN,
    .cmd, .dpIdle, .frameDone, .rxByte);

  spim_datapath u_dp (
    .clk, .rstN, .cmd, .miso, .sck, .mosi, .idle(dpIdle), .frameDone, .rxByte);
endmodule

// File: tb/spi_master_regs_bench.sv
`timescale 1ns/1ps
module spi_master_regs_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  busAddr = '0;
  logic        busWe = 1'b0, busRe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        sck, mosi, miso;
  logic [3:0]  csN;

  int checks = 0, fails = 0;
  logic       benchCpol = 1'b0, benchCpha = 1'b0;
  logic [7:0] monBits;
  int         monCnt;
  logic [3:0] monCs;
  realtime    prevT = 0.0, lastGap = 0.0;

  always #2 clk = ~clk;
  assign miso = mosi;

  spi_master_regs u_spi_master_regs (
    .clk, .rstN, .busAddr, .busWe, .busRe, .busWdata, .busRdata,
    .sck, .mosi, .miso, .csN);

  // records data and select on every sampling edge of the serial clock
  always @(sck) begin
    if (rstN) begin
      lastGap = $realtime - prevT;
      prevT = $realtime;
      if ((sck !== benchCpol) == (benchCpha == 1'b0)) begin
        monBits = {monBits[6:0], mosi};
        monCnt++;
        monCs = csN;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRe = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic monClear();
    monBits = 8'h00; monCnt = 0; monCs = 4'hF;
  endtask

  task automatic waitFrame(input int len, input int dv);
    repeat (2 * len * (dv + 1) + 6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tReset();
    logic [31:0] d;
    chk("R1 csN at reset", 32'(csN), 32'hF);
    chk("R1 sck idle low", 32'(sck), 32'h0);
    busRd(7'h00, d); chk("R1 divider reset", d, 32'd3);
    busRd(7'h04, d); chk("R1 clock mode reset", d, 32'd0);
    busRd(7'h10, d); chk("R1 select index reset", d, 32'd0);
    busRd(7'h18, d); chk("R1 select mode reset", d, 32'd0);
    busRd(7'h40, d); chk("R1 format reset", d, 32'h0008_0000);
    busRd(7'h14, d); chk("R11 default reg shows 4 lines", d, 32'hF);
    busRd(7'h48, d); chk("R5 tx not full at reset", d, 32'h0);
    busRd(7'h4C, d); chk("R6 rx empty at reset", d, 32'h8000_0000);
  endtask

  task automatic tBasic();
    logic [31:0] d;
    busWr(7'h00, 32'd0);
    monClear();
    busWr(7'h48, 32'hA5);
    waitFrame(8, 0);
    busRd(7'h4C, d); chk("R7 loopback byte", d, 32'hA5);
    chk("R4 bits MSB first", 32'(monBits), 32'hA5);
    chk("R4 eight bits", 32'(monCnt), 32'd8);
    chk("R2 half period div0", 32'(int'(lastGap)), 32'd4);
    busWr(7'h00, 32'd5);
    monClear();
    busWr(7'h48, 32'h5A);
    waitFrame(8, 5);
    chk("R2 half period div5", 32'(int'(lastGap)), 32'd24);
    busRd(7'h4C, d); chk("R7 loopback at div5", d, 32'h5A);
    busWr(7'h00, 32'd0);
  endtask

  task automatic tModes();
    logic [31:0] d;
    for (int m = 0; m < 4; m++) begin
      benchCpol = 1'(m >> 1); benchCpha = 1'(m);
      busWr(7'h04, 32'(m));
      repeat (2) @(negedge clk);
      chk("R3 idle level before frame", 32'(sck), 32'(benchCpol));
      monClear();
      busWr(7'h48, 32'h3C ^ 32'(m));
      waitFrame(8, 0);
      chk("R3 bits on sampling edges", 32'(monBits), 32'h3C ^ 32'(m));
      busRd(7'h4C, d); chk("R3 loopback in mode", d, 32'h3C ^ 32'(m));
      chk("R3 idle level after frame", 32'(sck), 32'(benchCpol));
    end
    benchCpol = 1'b0; benchCpha = 1'b0;
    busWr(7'h04, 32'd0);
    repeat (2) @(negedge clk);
  endtask

  task automatic tOrder();
    logic [31:0] d;
    busWr(7'h40, (32'd5 << 16) | 32'h4);
    monClear();
    busWr(7'h48, 32'h16);
    waitFrame(5, 0);
    chk("R4 five bits LSB first", 32'(monBits & 8'h1F), 32'h0D);
    chk("R4 five-bit count", 32'(monCnt), 32'd5);
    busRd(7'h4C, d); chk("R4 LSB-first rx aligned", d, 32'h16);
    busWr(7'h40, 32'd3 << 16);
    monClear();
    busWr(7'h48, 32'hFD);
    waitFrame(3, 0);
    chk("R4 three bits MSB first", 32'(monBits & 8'h07), 32'h5);
    chk("R4 three-bit count", 32'(monCnt), 32'd3);
    busRd(7'h4C, d); chk("R4 three-bit rx", d, 32'h5);
    busWr(7'h40, 32'd8 << 16);
  endtask

  task automatic tFifo();
    logic [31:0] d;
    busWr(7'h00, 32'd20);
    monClear();
    for (int i = 0; i < 9; i++) busWr(7'h48, 32'h11 + 32'(i));
    busRd(7'h48, d); chk("R5 tx full flag", d, 32'h8000_0000);
    busWr(7'h48, 32'h1A);
    repeat (9 * (16 * 21 + 3) + 50) @(posedge clk);
    @(negedge clk);
    chk("R7 stalls with rx full", 32'(monCnt), 32'd64);
    busRd(7'h48, d); chk("R5 tx no longer full", d, 32'h0);
    for (int i = 0; i < 8; i++) begin
      busRd(7'h4C, d); chk("R6 rx pops in order", d, 32'h11 + 32'(i));
    end
    waitFrame(8, 20);
    busRd(7'h4C, d); chk("R7 stalled frame resumes", d, 32'h19);
    busRd(7'h4C, d); chk("R6 empty read", d, 32'h8000_0000);
    waitFrame(8, 20);
    busRd(7'h4C, d); chk("R5 write when full dropped", d, 32'h8000_0000);
    busWr(7'h00, 32'd0);
  endtask

  task automatic tSelect();
    logic [31:0] d;
    busWr(7'h10, 32'd2);
    monClear();
    busWr(7'h48, 32'h01);
    waitFrame(8, 0);
    chk("R8 auto line active in frame", 32'(monCs), 32'hB);
    chk("R8 auto released after", 32'(csN), 32'hF);
    busRd(7'h4C, d);
    busWr(7'h18, 32'd2);
    monClear();
    busWr(7'h48, 32'h02);
    waitFrame(8, 0);
    chk("R9 hold active in frame", 32'(monCs), 32'hB);
    chk("R9 hold kept after frame", 32'(csN), 32'hB);
    busWr(7'h10, 32'd2);
    chk("R9 same-value write keeps hold", 32'(csN), 32'hB);
    busWr(7'h10, 32'd1);
    chk("R9 changed index releases", 32'(csN), 32'hF);
    busWr(7'h48, 32'h03);
    waitFrame(8, 0);
    chk("R9 hold on new line", 32'(csN), 32'hD);
    busWr(7'h18, 32'd0);
    chk("R9 mode change releases", 32'(csN), 32'hF);
    busRd(7'h4C, d); busRd(7'h4C, d);
    busWr(7'h18, 32'd3);
    monClear();
    busWr(7'h48, 32'h04);
    waitFrame(8, 0);
    chk("R10 off mode frame runs", 32'(monCnt), 32'd8);
    chk("R10 off mode no select", 32'(monCs), 32'hF);
    busRd(7'h4C, d); chk("R10 off mode data", d, 32'h04);
    busWr(7'h18, 32'd0);
    busWr(7'h10, 32'd0);
    busWr(7'h14, 32'hE);
    chk("R11 inverted idle level", 32'(csN), 32'hE);
    monClear();
    busWr(7'h48, 32'h05);
    waitFrame(8, 0);
    chk("R11 active-high line in frame", 32'(monCs), 32'hF);
    chk("R11 back to idle level", 32'(csN), 32'hE);
    busRd(7'h4C, d);
    busWr(7'h14, 32'hF);
  endtask

  task automatic tIgnored();
    logic [31:0] d;
    busWr(7'h28, 32'hFFFF_FFFF);
    busWr(7'h50, 32'hFFFF_FFFF);
    busWr(7'h70, 32'hFFFF_FFFF);
    busWr(7'h74, 32'hFFFF_FFFF);
    busRd(7'h28, d); chk("R12 delay reads 0", d, 32'h0);
    busRd(7'h50, d); chk("R12 mark reads 0", d, 32'h0);
    busRd(7'h70, d); chk("R12 enable reads 0", d, 32'h0);
    busRd(7'h74, d); chk("R12 pending reads 0", d, 32'h0);
    busRd(7'h00, d); chk("R12 divider untouched", d, 32'h0);
    busRd(7'h60, d); chk("R12 flash ctrl reset", d, 32'h1);
    busWr(7'h60, 32'h0);
    busRd(7'h60, d); chk("R12 flash ctrl stores", d, 32'h0);
    busWr(7'h40, (32'd8 << 16) | 32'h2);
    busRd(7'h40, d); chk("R12 lane field stored", d, 32'h0008_0002);
    monClear();
    busWr(7'h48, 32'h96);
    waitFrame(8, 0);
    chk("R12 still single lane", 32'(monBits), 32'h96);
    busRd(7'h4C, d); chk("R12 single-lane rx", d, 32'h96);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    monClear();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBasic();
    tModes();
    tOrder();
    tFifo();
    tSelect();
    tIgnored();
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end
endmodule